// File: doc/BRIEF.md
# ADC Link Calibration Sequencer

This block is the control state machine that brings a multi-lane serial link from a data converter up to live capture. When the capture-start input rises, it programs the converter through a write-request port, which an external SPI master serves. Each request carries a 15-bit register address and 8-bit data, and uses a valid/ready handshake.

Training runs in a fixed order of four phases. In the bit phase the sequencer turns the scrambler off, selects test pattern 1 and waits for clock/data recovery lock. In the word phase it selects pattern 2 and waits for word alignment. In the channel phase it selects pattern 3 and waits for lane deskew. In the data phase it selects live samples and waits until the one-time break word has been seen. If the scramble configuration input is set, it then turns the scrambler on. Finally it raises capture-enable, and downstream parity monitoring starts from that point.

Every wait state has a cycle-count timeout. On expiry the sequencer parks in a fault state and reports which phase failed. Dropping capture-start returns the block to idle from any state.

Top module: `link_train_seq`

States, in order: `S_IDLE`, `S_SCR_OFF`, `S_PAT_BIT`, `S_WAIT_CDR`, `S_PAT_WORD`, `S_WAIT_WORD`, `S_PAT_LANE`, `S_WAIT_LANE`, `S_PAT_LIVE`, `S_WAIT_BRK`, `S_SCR_ON`, `S_CAPTURE`, `S_FAULT`.

Transitions:
- `S_IDLE` to `S_SCR_OFF` when capture-start is high.
- A write state moves to the next state in the list after a cycle in which valid and ready are both high.
- A wait state moves to the next write state when its status input is high. It moves to `S_FAULT` on expiry.
- `S_WAIT_BRK` moves to `S_SCR_ON` or to `S_CAPTURE`, depending on the scramble configuration input.
- `S_SCR_ON` moves to `S_CAPTURE` on a handshake.
- Capture-start low moves any state to `S_IDLE`.

## Requirements
- R1: After reset, and while cap_start is low, wr_valid, cap_en and train_err are 0 and err_phase is 0.
- R2: When cap_start is high in idle, the first request is address 0x4B1 with data 0x00, and the second is address 0x4A0 with data 0x01.
- R3: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data stay unchanged. The next request, or the wait state, appears in the cycle after the cycle in which valid and ready are both high.
- R4: After the pattern 1 write the block issues nothing until cdr_lock is high. It then writes 0x4A0 = 0x02. The other status inputs have no effect in this wait.
- R5: After the pattern 2 write it waits for word_ok and then writes 0x4A0 = 0x03. The other status inputs are ignored.
- R6: After the pattern 3 write it waits for lane_ok and then writes 0x4A0 = 0x00. The other status inputs are ignored.
- R7: After the live-data write it waits for brk_seen. If scr_cfg is 1 in that cycle, it then writes 0x4B1 = 0x01 before capture. If scr_cfg is 0, it goes straight to capture.
- R8: In the final state cap_en is 1 and wr_valid is 0, and this holds while cap_start stays high.
- R9: A wait state counts cycles from 0 on entry. If its status input is still low in the cycle in which the count equals tmo_limit, the next cycle shows train_err = 1 and err_phase holds the failed phase: 1 = clock recovery, 2 = word, 3 = channel, 4 = break word.
- R10: A status input that is high in the same cycle in which the count reaches tmo_limit advances the sequence, and no fault occurs.
- R11: train_err and err_phase hold, and status inputs are ignored, until cap_start goes low. One cycle after that, both read 0.
- R12: cap_start low in any state gives wr_valid = 0, cap_en = 0 and train_err = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_start | input | 1 | Start training; low aborts to idle |
| scr_cfg | input | 1 | Turn the scrambler on after the break word |
| tmo_limit | input | TMO_W | Timeout, in cycles, for each wait state |
| cdr_lock | input | 1 | Receiver clock/data recovery locked |
| word_ok | input | 1 | Word alignment confirmed |
| lane_ok | input | 1 | Lanes deskewed |
| brk_seen | input | 1 | Break word observed |
| wr_valid | output | 1 | Register write request valid |
| wr_ready | input | 1 | SPI master accepts the request |
| wr_addr | output | 15 | Converter register address |
| wr_data | output | 8 | Converter register data |
| cap_en | output | 1 | Data capture enabled |
| train_err | output | 1 | Training timed out |
| err_phase | output | 3 | Code of the phase that timed out |

## Verification
Two functions can fall in the same cycle: a phase's status input can arrive in the very cycle in which that wait state's count reaches tmo_limit. Directed runs provoke this by holding each status low for exactly tmo_limit cycles and raising it in the next one. The check is that the next write request appears and train_err stays low. Runs with one cycle more of delay must instead report the fault with the matching phase code.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int PH_W   = 3;

    localparam logic [ADDR_W-1:0] A_SCRAMBLE = 15'h4B1;
    localparam logic [ADDR_W-1:0] A_PATTERN  = 15'h4A0;

    typedef enum logic [3:0] {
        S_IDLE, S_SCR_OFF, S_PAT_BIT, S_WAIT_CDR, S_PAT_WORD, S_WAIT_WORD,
        S_PAT_LANE, S_WAIT_LANE, S_PAT_LIVE, S_WAIT_BRK, S_SCR_ON,
        S_CAPTURE, S_FAULT
    } lt_state_e;

    typedef enum logic [PH_W-1:0] {
        PH_NONE = 3'd0, PH_BIT = 3'd1, PH_WORD = 3'd2,
        PH_LANE = 3'd3, PH_BRK = 3'd4
    } lt_phase_e;

    function automatic lt_phase_e phase_of(lt_state_e s);
        unique case (s)
            S_WAIT_CDR:  return PH_BIT;
            S_WAIT_WORD: return PH_WORD;
            S_WAIT_LANE: return PH_LANE;
            S_WAIT_BRK:  return PH_BRK;
            default:     return PH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lt_status_sel.sv
module lt_status_sel
    import lt_pkg::*;
(
    input  lt_phase_e phase,
    input  logic      cdr_lock,
    input  logic      word_ok,
    input  logic      lane_ok,
    input  logic      brk_seen,
    output logic      hit
);

    always_comb begin
        unique case (phase)
            PH_BIT:  hit = cdr_lock;
            PH_WORD: hit = word_ok;
            PH_LANE: hit = lane_ok;
            PH_BRK:  hit = brk_seen;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt;

    assign expired = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr || !run)   cnt <= '0;
        else if (!expired)      cnt <= cnt + 1'b1;
    end

    // R9: the count steps by one each waiting cycle before expiry
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !expired) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
    import lt_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_start,
    input  logic              scr_cfg,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              cdr_lock,
    input  logic              word_ok,
    input  logic              lane_ok,
    input  logic              brk_seen,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [14:0]       wr_addr,
    output logic [7:0]        wr_data,
    output logic              cap_en,
    output logic              train_err,
    output logic [2:0]        err_phase
);

    lt_state_e state, nxt;
    lt_phase_e phase, fault_ph;
    logic      is_wait, hit, expired, tmr_clr;

    assign phase   = phase_of(state);
    assign is_wait = (phase != PH_NONE);
    assign tmr_clr = (nxt != state);

    lt_status_sel u_sel (
        .phase    (phase),
        .cdr_lock (cdr_lock),
        .word_ok  (word_ok),
        .lane_ok  (lane_ok),
        .brk_seen (brk_seen),
        .hit      (hit)
    );

    lt_wait_timer #(.W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (is_wait),
        .limit   (tmo_limit),
        .expired (expired)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (!cap_start) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_SCR_OFF;
                S_SCR_OFF:   if (wr_ready) nxt = S_PAT_BIT;
                S_PAT_BIT:   if (wr_ready) nxt = S_WAIT_CDR;
                S_WAIT_CDR:  if (hit) nxt = S_PAT_WORD;
                             else if (expired) nxt = S_FAULT;
                S_PAT_WORD:  if (wr_ready) nxt = S_WAIT_WORD;
                S_WAIT_WORD: if (hit) nxt = S_PAT_LANE;
                             else if (expired) nxt = S_FAULT;
                S_PAT_LANE:  if (wr_ready) nxt = S_WAIT_LANE;
                S_WAIT_LANE: if (hit) nxt = S_PAT_LIVE;
                             else if (expired) nxt = S_FAULT;
                S_PAT_LIVE:  if (wr_ready) nxt = S_WAIT_BRK;
                S_WAIT_BRK:  if (hit) nxt = scr_cfg ? S_SCR_ON : S_CAPTURE;
                             else if (expired) nxt = S_FAULT;
                S_SCR_ON:    if (wr_ready) nxt = S_CAPTURE;
                S_CAPTURE:   nxt = S_CAPTURE;
                S_FAULT:     nxt = S_FAULT;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // state register and failed-phase record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            fault_ph <= PH_NONE;
        end else begin
            state <= nxt;
            if (!cap_start)
                fault_ph <= PH_NONE;
            else if (is_wait && !hit && expired)
                fault_ph <= phase;
        end
    end

    // outputs decoded from state
    always_comb begin
        wr_valid  = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        cap_en    = 1'b0;
        train_err = 1'b0;
        err_phase = '0;
        unique case (state)
            S_SCR_OFF:  begin wr_valid = 1'b1; wr_addr = A_SCRAMBLE; wr_data = 8'h00; end
            S_PAT_BIT:  begin wr_valid = 1'b1; wr_addr = A_PATTERN;  wr_data = 8'h01; end
            S_PAT_WORD: begin wr_valid = 1'b1; wr_addr = A_PATTERN;  wr_data = 8'h02; end
            S_PAT_LANE: begin wr_valid = 1'b1; wr_addr = A_PATTERN;  wr_data = 8'h03; end
            S_PAT_LIVE: begin wr_valid = 1'b1; wr_addr = A_PATTERN;  wr_data = 8'h00; end
            S_SCR_ON:   begin wr_valid = 1'b1; wr_addr = A_SCRAMBLE; wr_data = 8'h01; end
            S_CAPTURE:  cap_en = 1'b1;
            S_FAULT:    begin train_err = 1'b1; err_phase = fault_ph; end
            default:    ;
        endcase
    end

    // R2: training opens by clearing the scrambler
    p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cap_start) |=>
            (wr_valid && wr_addr == A_SCRAMBLE && wr_data == 8'h00));

    // R3: an unaccepted request is held unchanged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && cap_start) |=>
            (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R8: capture follows only the break wait or the scrambler-on write
    p_capture_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_en) |-> $past(state == S_WAIT_BRK || state == S_SCR_ON));

    // R9: a fault always carries a valid phase code
    p_fault_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        train_err |-> (err_phase != 3'd0 && err_phase <= 3'd4));

    // R10: an arriving status never leads into a fault
    p_status_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wait && hit && cap_start) |=> !train_err);

    // R11: the fault report holds while start stays high
    p_fault_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (train_err && cap_start) |=> (train_err && $stable(err_phase)));

    // R12: dropping start quiets every output
    p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_start |=> (!wr_valid && !cap_en && !train_err));

endmodule

// File: tb/sim_link_train_seq.sv
`timescale 1ns/1ps
module sim_link_train_seq;

    localparam int TW    = 16;
    localparam int LIMIT = 6;

    logic clk = 1'b0;
    logic rst_n, cap_start, scr_cfg, wr_ready;
    logic cdr_lock, word_ok, lane_ok, brk_seen;
    logic [TW-1:0] tmo_limit;
    logic wr_valid, cap_en, train_err;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;
    logic [2:0]  err_phase;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    link_train_seq #(.TMO_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .scr_cfg(scr_cfg),
        .tmo_limit(tmo_limit), .cdr_lock(cdr_lock), .word_ok(word_ok),
        .lane_ok(lane_ok), .brk_seen(brk_seen), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_en(cap_en), .train_err(train_err), .err_phase(err_phase)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected write sequence, from the requirements
    function automatic logic [7:0] pat_after(input int ph);
        return (ph == 1) ? 8'h02 : (ph == 2) ? 8'h03 : 8'h00;
    endfunction

    function automatic string req_of(input int ph);
        return (ph == 1) ? "R4" : (ph == 2) ? "R5" : (ph == 3) ? "R6" : "R7";
    endfunction

    task automatic drive_st(input int ph, input bit v);
        cdr_lock = (ph == 1) ? v : 1'($urandom_range(0, 1));
        word_ok  = (ph == 2) ? v : 1'($urandom_range(0, 1));
        lane_ok  = (ph == 3) ? v : 1'($urandom_range(0, 1));
        brk_seen = (ph == 4) ? v : 1'($urandom_range(0, 1));
    endtask

    task automatic clear_st();
        cdr_lock = 0; word_ok = 0; lane_ok = 0; brk_seen = 0;
    endtask

    task automatic check_idle(input string req);
        chk(wr_valid == 0, req, "wr_valid", wr_valid, 0);
        chk(cap_en == 0, req, "cap_en", cap_en, 0);
        chk(train_err == 0, req, "train_err", train_err, 0);
        chk(err_phase == 0, req, "err_phase", err_phase, 0);
    endtask

    task automatic accept_write(input logic [14:0] ea, input logic [7:0] ed,
                                input string req);
        int lat = $urandom_range(0, 3);
        for (int i = 0; i <= lat; i++) begin
            chk(wr_valid == 1, req, "wr_valid", wr_valid, 1);
            chk(wr_addr == ea, req, "wr_addr", wr_addr, ea);
            chk(wr_data == ed, (i > 0) ? "R3" : req, "wr_data", wr_data, ed);
            wr_ready = (i == lat);
            @(negedge clk);
        end
        wr_ready = 0;
    endtask

    task automatic wait_status(input int ph, input int lat);
        for (int i = 0; i <= lat; i++) begin
            if (i < lat) begin
                chk(wr_valid == 0, req_of(ph), "wr_valid in wait", wr_valid, 0);
                chk(train_err == 0, req_of(ph), "train_err in wait", train_err, 0);
            end
            drive_st(ph, i == lat);
            @(negedge clk);
        end
        clear_st();
    endtask

    task automatic wait_fail(input int ph);
        for (int i = 0; i <= LIMIT; i++) begin
            chk(train_err == 0, "R9", "early fault", train_err, 0);
            drive_st(ph, 1'b0);
            @(negedge clk);
        end
        clear_st();
        chk(train_err == 1, "R9", "train_err", train_err, 1);
        chk(err_phase == 3'(ph), "R9", "err_phase", err_phase, ph);
        chk(wr_valid == 0 && cap_en == 0, "R9", "outputs in fault", wr_valid, 0);
        for (int i = 0; i < 3; i++) begin
            drive_st(ph, 1'b1);
            @(negedge clk);
            chk(train_err == 1, "R11", "train_err held", train_err, 1);
            chk(err_phase == 3'(ph), "R11", "err_phase held", err_phase, ph);
        end
        clear_st();
        cap_start = 0;
        @(negedge clk);
        chk(train_err == 0, "R11", "train_err cleared", train_err, 0);
        chk(err_phase == 0, "R11", "err_phase cleared", err_phase, 0);
        @(negedge clk);
    endtask

    task automatic train(input int fail_ph, input bit scr, input bit edge_lat);
        scr_cfg   = scr;
        cap_start = 1;
        @(negedge clk);
        accept_write(15'h4B1, 8'h00, "R2");
        accept_write(15'h4A0, 8'h01, "R2");
        for (int ph = 1; ph <= 4; ph++) begin
            if (ph == fail_ph) begin
                wait_fail(ph);
                return;
            end
            wait_status(ph, edge_lat ? LIMIT : $urandom_range(0, LIMIT));
            if (ph < 4)
                accept_write(15'h4A0, pat_after(ph), edge_lat ? "R10" : req_of(ph));
        end
        if (scr)
            accept_write(15'h4B1, 8'h01, "R7");
        for (int i = 0; i < 3; i++) begin
            chk(cap_en == 1, scr ? "R8" : "R7", "cap_en", cap_en, 1);
            chk(wr_valid == 0, "R8", "wr_valid in capture", wr_valid, 0);
            chk(train_err == 0, "R10", "no fault", train_err, 0);
            @(negedge clk);
        end
        cap_start = 0;
        @(negedge clk);
        check_idle("R12");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        rst_n = 0; cap_start = 0; scr_cfg = 0; wr_ready = 0;
        tmo_limit = TW'(LIMIT);
        clear_st();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_idle("R1");
        drive_st(0, 1'b0);
        repeat (2) @(negedge clk);
        check_idle("R1");
        clear_st();

        // status on the timeout cycle, scrambling on and off
        train(0, 1'b1, 1'b1);
        train(0, 1'b0, 1'b1);

        // timeout in every phase
        for (int p = 1; p <= 4; p++)
            train(p, 1'($urandom_range(0, 1)), 1'b0);

        // abort while a request is pending
        cap_start = 1;
        @(negedge clk);
        accept_write(15'h4B1, 8'h00, "R2");
        chk(wr_valid == 1, "R12", "pending request", wr_valid, 1);
        cap_start = 0;
        @(negedge clk);
        check_idle("R12");

        // random runs
        for (int n = 0; n < 16; n++)
            train(0, 1'($urandom_range(0, 1)), 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule